// File: doc/BRIEF.md
# Swizzled Buffer Address Generator

This block turns one vector buffer access of a 64-lane wavefront into per-lane byte addresses. A single start pulse captures the buffer descriptor fields, a scalar offset, an immediate offset, the per-lane index and offset vectors and the execution mask. The block then walks the lanes in ascending order, one lane per clock. For each lane it reports whether the lane is active and, for active lanes, a byte address and an out-of-bounds flag.

Two addressing modes are supported. Linear mode places record `index` at `stride * index`. Swizzled mode interleaves the records in tiles: the index is split by a programmable index stride and the offset is split by a programmable element size. An optional thread-ID term adds the lane number to the index and widens the stride with the descriptor's format field. Each mode has its own bounds rule.

Once the last lane has been reported, the block presents the execution mask with every out-of-bounds lane cleared. The memory request that follows uses this mask.

Top module: `swz_addr_gen`

## Requirements
- R1: While reset is held and after it is released, `busy`, `lane_vld`, `lane_oob` and `done` are low and `mask_out` is all zeros.
- R2: A `start` sampled high while `busy` is low captures every input. `busy` is high from the next cycle. The result for lane i (i = 0..63, in ascending order) appears on the outputs after the (i+1)-th rising edge that follows the capturing edge, with `lane_num` = i. A `start` sampled while `busy` is high has no effect on any output.
- R3: `lane_vld` is high for lane i exactly when bit i of the captured `exec_in` is set. `lane_oob` is never high when `lane_vld` is low.
- R4: The effective stride is `d_fmt * 16384 + d_stride` when `d_tid_en` is 1, and `d_stride` when it is 0.
- R5: The lane's index is its field of `idx_vec` (lane i at bits [32i+31:32i]) plus i when `d_tid_en` is 1. The lane's offset is its field of `off_vec` (same layout) plus `i_off`. Both sums are computed without truncation.
- R6: When the effective stride is 0 or `d_swz_en` is 0 (linear mode), the address is `d_base + s_off + offset + stride * index`, taken modulo 2^48.
- R7: In linear mode a lane is out of bounds when `offset + stride * index >= L`. Here L is `d_nrec - s_off` if `d_nrec > s_off`, and 0 otherwise, so every active lane is out of bounds when `s_off >= d_nrec`.
- R8: When the effective stride is nonzero and `d_swz_en` is 1 (swizzled mode), let T = 8 << `d_istr_sel` and E = 2 << `d_esz_sel`. The address is `d_base + s_off + ((index / T) * stride + (offset / E) * E) * T + (index % T) * E + offset % E`, taken modulo 2^48.
- R9: In swizzled mode a lane is out of bounds when `index >= d_nrec` or `offset >= stride`.
- R10: `done` is high for exactly one cycle, together with the lane 63 result. `busy` is low from that same cycle. From then on, `mask_out` equals the captured `exec_in` with the bit of every out-of-bounds lane cleared, and it holds that value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a wavefront; captured only when idle |
| d_base | input | 48 | Descriptor base byte address |
| d_stride | input | 14 | Descriptor record stride in bytes |
| d_fmt | input | 4 | Descriptor format field, stride high part in thread-ID mode |
| d_nrec | input | 32 | Descriptor record count / byte limit |
| d_swz_en | input | 1 | Swizzled addressing enable |
| d_tid_en | input | 1 | Thread-ID indexing enable |
| d_istr_sel | input | 2 | Index stride select, T = 8 << value |
| d_esz_sel | input | 2 | Element size select, E = 2 << value |
| s_off | input | 32 | Scalar byte offset |
| i_off | input | 12 | Instruction immediate offset |
| idx_vec | input | 2048 | Per-lane index, 32 bits per lane |
| off_vec | input | 2048 | Per-lane offset, 32 bits per lane |
| exec_in | input | 64 | Execution mask, bit i = lane i |
| busy | output | 1 | A wavefront is being walked |
| lane_vld | output | 1 | The reported lane is active |
| lane_num | output | 6 | Number of the reported lane |
| lane_addr | output | 48 | Byte address of the reported lane |
| lane_oob | output | 1 | The reported lane is out of bounds |
| done | output | 1 | The last lane is being reported |
| mask_out | output | 64 | Execution mask with out-of-bounds lanes cleared |

## Verification
Each accepted start has a fixed schedule. `busy` is due one edge after the capturing edge. Lane i's number, valid flag, address and bounds flag are due i+1 edges after it. `done`, the falling `busy` and the final `mask_out` are due together with lane 63. The bench drives inputs at falling edges and counts rising edges from the capturing one. It samples each lane's result at the falling edge that follows the edge on which that result is due, so each value is read exactly in the cycle in which it is valid. The expected mask is checked again one cycle later to confirm that it holds. A start pulse raised in the middle of a wavefront, with every input changed, must leave that wavefront's remaining results unchanged.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int STRIDE_W = 14;
  localparam int FMT_W    = 4;
  localparam int NREC_W   = 32;
  localparam int SOFF_W   = 32;
  localparam int SEL_W    = 2;
  localparam int ESTR_W   = STRIDE_W + FMT_W;

  // descriptor fields used for address generation (base kept apart, width is a parameter)
  typedef struct packed {
    logic [STRIDE_W-1:0] stride;
    logic [FMT_W-1:0]    fmt;
    logic [NREC_W-1:0]   nrec;
    logic                swz_en;
    logic                tid_en;
    logic [SEL_W-1:0]    istr_sel;
    logic [SEL_W-1:0]    esz_sel;
  } desc_ctl_t;

  typedef enum logic {
    MODE_LINEAR  = 1'b0,
    MODE_SWIZZLE = 1'b1
  } addr_mode_e;
endpackage

// File: rtl/swz_lane_calc.sv
module swz_lane_calc
  import swz_pkg::*;
#(
  parameter int AW     = 48,
  parameter int IW     = 32,
  parameter int IOFF_W = 12,
  parameter int LN_W   = 6
) (
  input  desc_ctl_t         desc,
  input  logic [AW-1:0]     base,
  input  logic [SOFF_W-1:0] soff,
  input  logic [IOFF_W-1:0] ioff,
  input  logic [IW-1:0]     idx_in,
  input  logic [IW-1:0]     off_in,
  input  logic [LN_W-1:0]   lane,
  output logic [AW-1:0]     addr,
  output logic              oob
);
  localparam int BI_W = IW + 1;
  localparam int BO_W = IW + 1;
  localparam int CW   = BI_W + ESTR_W + 4;

  function automatic logic [ESTR_W-1:0] eff_stride(desc_ctl_t d);
    logic [ESTR_W-1:0] hi;
    hi = {d.fmt, {STRIDE_W{1'b0}}};
    return d.tid_en ? (hi + ESTR_W'(d.stride)) : ESTR_W'(d.stride);
  endfunction

  function automatic logic [BI_W-1:0] buf_index(logic [IW-1:0] idx, logic [LN_W-1:0] ln,
                                                logic tid);
    return BI_W'(idx) + (tid ? BI_W'(ln) : BI_W'(0));
  endfunction

  function automatic logic [BO_W-1:0] buf_offset(logic [IW-1:0] off, logic [IOFF_W-1:0] imm);
    return BO_W'(off) + BO_W'(imm);
  endfunction

  function automatic logic [CW-1:0] linear_rel(logic [BI_W-1:0] bi, logic [BO_W-1:0] bo,
                                               logic [ESTR_W-1:0] st);
    return CW'(bo) + CW'(bi) * CW'(st);
  endfunction

  function automatic logic [CW-1:0] linear_limit(logic [NREC_W-1:0] nrec, logic [SOFF_W-1:0] so);
    return (nrec > so) ? CW'(nrec - so) : CW'(0);
  endfunction

  function automatic logic [CW-1:0] swizzle_rel(logic [BI_W-1:0] bi, logic [BO_W-1:0] bo,
                                                logic [ESTR_W-1:0] st,
                                                logic [SEL_W-1:0] isel, logic [SEL_W-1:0] esel);
    int unsigned ish;
    int unsigned esh;
    logic [CW-1:0] iq, ir, oq, orr;
    ish = 32'd3 + 32'(isel);
    esh = 32'd1 + 32'(esel);
    iq  = CW'(bi) >> ish;
    ir  = CW'(bi) & ((CW'(1) << ish) - CW'(1));
    oq  = CW'(bo) >> esh;
    orr = CW'(bo) & ((CW'(1) << esh) - CW'(1));
    return ((iq * CW'(st) + (oq << esh)) << ish) + (ir << esh) + orr;
  endfunction

  logic [ESTR_W-1:0] stride;
  logic [BI_W-1:0]   bidx;
  logic [BO_W-1:0]   boff;
  logic [CW-1:0]     rel;
  addr_mode_e        mode;

  always_comb begin
    stride = eff_stride(desc);
    bidx   = buf_index(idx_in, lane, desc.tid_en);
    boff   = buf_offset(off_in, ioff);
    mode   = (desc.swz_en && (stride != '0)) ? MODE_SWIZZLE : MODE_LINEAR;
    if (mode == MODE_SWIZZLE) begin
      rel = swizzle_rel(bidx, boff, stride, desc.istr_sel, desc.esz_sel);
      oob = (CW'(bidx) >= CW'(desc.nrec)) || (CW'(boff) >= CW'(stride));
    end else begin
      rel = linear_rel(bidx, boff, stride);
      oob = rel >= linear_limit(desc.nrec, soff);
    end
    addr = base + AW'(soff) + AW'(rel);
  end
endmodule

// File: rtl/swz_lane_seq.sv
module swz_lane_seq #(
  parameter int LANES = 64,
  parameter int LN_W  = $clog2(LANES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output logic            busy,
  output logic            accept,
  output logic            step,
  output logic            last,
  output logic [LN_W-1:0] lane
);
  localparam logic [LN_W-1:0] LAST_LANE = LN_W'(LANES - 1);

  logic [LN_W-1:0] cnt;

  assign accept = start && !busy;
  assign step   = busy;
  assign last   = busy && (cnt == LAST_LANE);
  assign lane   = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/swz_mask_acc.sv
module swz_mask_acc #(
  parameter int LANES = 64,
  parameter int LN_W  = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LANES-1:0] load_val,
  input  logic             clr_en,
  input  logic [LN_W-1:0]  clr_idx,
  output logic [LANES-1:0] mask
);
  for (genvar g = 0; g < LANES; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                                   mask[g] <= 1'b0;
      else if (load)                                mask[g] <= load_val[g];
      else if (clr_en && (clr_idx == LN_W'(g)))     mask[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/swz_addr_gen.sv
module swz_addr_gen
  import swz_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int AW     = 48,
  parameter int IW     = 32,
  parameter int IOFF_W = 12,
  localparam int LN_W  = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [AW-1:0]       d_base,
  input  logic [STRIDE_W-1:0] d_stride,
  input  logic [FMT_W-1:0]    d_fmt,
  input  logic [NREC_W-1:0]   d_nrec,
  input  logic                d_swz_en,
  input  logic                d_tid_en,
  input  logic [SEL_W-1:0]    d_istr_sel,
  input  logic [SEL_W-1:0]    d_esz_sel,
  input  logic [SOFF_W-1:0]   s_off,
  input  logic [IOFF_W-1:0]   i_off,
  input  logic [LANES*IW-1:0] idx_vec,
  input  logic [LANES*IW-1:0] off_vec,
  input  logic [LANES-1:0]    exec_in,
  output logic                busy,
  output logic                lane_vld,
  output logic [LN_W-1:0]     lane_num,
  output logic [AW-1:0]       lane_addr,
  output logic                lane_oob,
  output logic                done,
  output logic [LANES-1:0]    mask_out
);
  // captured operands
  desc_ctl_t           desc_q;
  logic [AW-1:0]       base_q;
  logic [SOFF_W-1:0]   soff_q;
  logic [IOFF_W-1:0]   ioff_q;
  logic [LANES*IW-1:0] idx_vec_q;
  logic [LANES*IW-1:0] off_vec_q;
  logic [LANES-1:0]    exec_q;

  // named internal events
  logic            accept;
  logic            step;
  logic            last;
  logic [LN_W-1:0] lane;
  logic            lane_act;
  logic            cur_oob;
  logic            clr_fire;
  logic [AW-1:0]   cur_addr;
  logic            step_q;

  logic [IW-1:0] idx_arr [LANES];
  logic [IW-1:0] off_arr [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign idx_arr[g] = idx_vec_q[g*IW +: IW];
    assign off_arr[g] = off_vec_q[g*IW +: IW];
  end

  swz_lane_seq #(.LANES(LANES), .LN_W(LN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .accept(accept), .step(step), .last(last), .lane(lane)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      desc_q    <= '0;
      base_q    <= '0;
      soff_q    <= '0;
      ioff_q    <= '0;
      idx_vec_q <= '0;
      off_vec_q <= '0;
      exec_q    <= '0;
    end else if (accept) begin
      desc_q    <= '{stride: d_stride, fmt: d_fmt, nrec: d_nrec, swz_en: d_swz_en,
                     tid_en: d_tid_en, istr_sel: d_istr_sel, esz_sel: d_esz_sel};
      base_q    <= d_base;
      soff_q    <= s_off;
      ioff_q    <= i_off;
      idx_vec_q <= idx_vec;
      off_vec_q <= off_vec;
      exec_q    <= exec_in;
    end
  end

  swz_lane_calc #(.AW(AW), .IW(IW), .IOFF_W(IOFF_W), .LN_W(LN_W)) u_calc (
    .desc(desc_q), .base(base_q), .soff(soff_q), .ioff(ioff_q),
    .idx_in(idx_arr[lane]), .off_in(off_arr[lane]), .lane(lane),
    .addr(cur_addr), .oob(cur_oob)
  );

  assign lane_act = step && exec_q[lane];
  assign clr_fire = lane_act && cur_oob;

  swz_mask_acc #(.LANES(LANES), .LN_W(LN_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(exec_in),
    .clr_en(clr_fire), .clr_idx(lane), .mask(mask_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q    <= 1'b0;
      lane_vld  <= 1'b0;
      lane_oob  <= 1'b0;
      done      <= 1'b0;
      lane_num  <= '0;
      lane_addr <= '0;
    end else begin
      step_q   <= step;
      lane_vld <= lane_act;
      lane_oob <= clr_fire;
      done     <= last;
      if (step) begin
        lane_num  <= lane;
        lane_addr <= lane_act ? cur_addr : '0;
      end
    end
  end
endmodule

module swz_addr_gen_chk #(
  parameter int LANES = 64,
  parameter int LN_W  = $clog2(LANES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             accept,
  input logic             step_q,
  input logic             lane_vld,
  input logic             lane_oob,
  input logic [LN_W-1:0]  lane_num,
  input logic             done,
  input logic [LANES-1:0] mask_out
);
  // R3
  oob_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_oob |-> lane_vld);

  // R3
  vld_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_vld |-> step_q);

  // R2
  lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q && !done) |=> (step_q && lane_num == LN_W'($past(lane_num) + 1'b1)));

  // R10
  done_last_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (step_q && lane_num == LN_W'(LANES - 1) && !busy));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  mask_only_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ((mask_out & ~$past(mask_out)) == '0));

  // R10
  oob_clears_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_oob |-> !mask_out[lane_num]);

  // R10
  inb_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_vld && !lane_oob) |-> mask_out[lane_num]);
endmodule

bind swz_addr_gen swz_addr_gen_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .accept(accept), .step_q(step_q),
  .lane_vld(lane_vld), .lane_oob(lane_oob), .lane_num(lane_num), .done(done),
  .mask_out(mask_out)
);

// File: tb/swz_addr_gen_test.sv
module swz_addr_gen_test;
  localparam int LANES = 64;
  localparam int AW    = 48;
  localparam int IW    = 32;
  localparam int IOFF_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] d_base = '0;
  logic [13:0] d_stride = '0;
  logic [3:0] d_fmt = '0;
  logic [31:0] d_nrec = '0;
  logic d_swz_en = 1'b0, d_tid_en = 1'b0;
  logic [1:0] d_istr_sel = '0, d_esz_sel = '0;
  logic [31:0] s_off = '0;
  logic [IOFF_W-1:0] i_off = '0;
  logic [LANES*IW-1:0] idx_vec = '0, off_vec = '0;
  logic [LANES-1:0] exec_in = '0;
  logic busy, lane_vld, lane_oob, done;
  logic [5:0] lane_num;
  logic [AW-1:0] lane_addr;
  logic [LANES-1:0] mask_out;

  swz_addr_gen #(.LANES(LANES), .AW(AW), .IW(IW), .IOFF_W(IOFF_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .d_base(d_base), .d_stride(d_stride),
    .d_fmt(d_fmt), .d_nrec(d_nrec), .d_swz_en(d_swz_en), .d_tid_en(d_tid_en),
    .d_istr_sel(d_istr_sel), .d_esz_sel(d_esz_sel), .s_off(s_off), .i_off(i_off),
    .idx_vec(idx_vec), .off_vec(off_vec), .exec_in(exec_in), .busy(busy),
    .lane_vld(lane_vld), .lane_num(lane_num), .lane_addr(lane_addr), .lane_oob(lane_oob),
    .done(done), .mask_out(mask_out)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // snapshot taken when a start is accepted
  longint unsigned m_base, m_stride, m_fmt, m_nrec, m_soff, m_ioff;
  bit m_swz, m_tid;
  longint unsigned m_istr, m_esz;
  logic [LANES*IW-1:0] m_idxv, m_offv;
  logic [LANES-1:0] m_exec;

  task automatic check(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model from the requirements, using divide and modulo
  task automatic model(input int ln, output longint unsigned a, output bit o);
    longint unsigned st, bi, bo, t, e, lim, span;
    st = m_tid ? (m_fmt * 64'd16384 + m_stride) : m_stride;           // R4
    bi = 64'(m_idxv[ln*IW +: IW]) + (m_tid ? 64'(ln) : 64'd0);        // R5
    bo = 64'(m_offv[ln*IW +: IW]) + m_ioff;                           // R5
    if (st != 0 && m_swz) begin                                       // R8, R9
      t = 64'd8 << m_istr;
      e = 64'd2 << m_esz;
      a = m_base + m_soff + ((bi / t) * st + (bo / e) * e) * t + (bi % t) * e + (bo % e);
      o = (bi >= m_nrec) || (bo >= st);
    end else begin                                                    // R6, R7
      span = bo + st * bi;
      lim  = (m_nrec > m_soff) ? (m_nrec - m_soff) : 64'd0;
      a = m_base + m_soff + span;
      o = span >= lim;
    end
    a = a & ((64'd1 << AW) - 64'd1);
  endtask

  task automatic take_snapshot();
    m_base = 64'(d_base); m_stride = 64'(d_stride); m_fmt = 64'(d_fmt);
    m_nrec = 64'(d_nrec); m_soff = 64'(s_off); m_ioff = 64'(i_off);
    m_swz = d_swz_en; m_tid = d_tid_en; m_istr = 64'(d_istr_sel); m_esz = 64'(d_esz_sel);
    m_idxv = idx_vec; m_offv = off_vec; m_exec = exec_in;
  endtask

  task automatic scramble();
    d_base = {$urandom, $urandom};
    d_stride = 14'($urandom);
    d_fmt = 4'($urandom);
    d_nrec = $urandom;
    d_swz_en = 1'($urandom);
    d_tid_en = 1'($urandom);
    d_istr_sel = 2'($urandom);
    d_esz_sel = 2'($urandom);
    s_off = $urandom;
    i_off = 12'($urandom);
    exec_in = {$urandom, $urandom};
    for (int i = 0; i < LANES; i++) begin
      idx_vec[i*IW +: IW] = $urandom;
      off_vec[i*IW +: IW] = $urandom;
    end
  endtask

  task automatic run_wave(input bit disturb);
    longint unsigned ea;
    bit eo;
    logic [LANES-1:0] emask;
    @(negedge clk);
    start = 1'b1;
    take_snapshot();
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy after accept", 64'(busy), 1);
    emask = m_exec;
    for (int i = 0; i < LANES; i++) begin
      @(negedge clk);
      model(i, ea, eo);
      check(lane_num === 6'(i), "R2 lane order", 64'(lane_num), 64'(i));
      check(lane_vld === m_exec[i], "R3 lane valid", 64'(lane_vld), 64'(m_exec[i]));
      if (m_exec[i]) begin
        check(64'(lane_addr) == ea, "R4/R5/R6/R8 address", 64'(lane_addr), ea);
        check(lane_oob === eo, "R7/R9 bounds", 64'(lane_oob), 64'(eo));
        if (eo) emask[i] = 1'b0;
      end else begin
        check(lane_oob === 1'b0, "R3 inactive no oob", 64'(lane_oob), 0);
      end
      check(done === (i == LANES - 1), "R10 done timing", 64'(done), 64'(i == LANES - 1));
      if (disturb && i == 10) begin
        scramble();
        start = 1'b1;
      end
      if (disturb && i == 12) start = 1'b0;
    end
    check(busy === 1'b0, "R10 busy drops with done", 64'(busy), 0);
    check(mask_out === emask, "R10 final mask", 64'(mask_out), 64'(emask));
    @(negedge clk);
    check(done === 1'b0, "R10 done single cycle", 64'(done), 0);
    check(mask_out === emask, "R10 mask holds", 64'(mask_out), 64'(emask));
  endtask

  task automatic set_vectors(input int kind);
    for (int i = 0; i < LANES; i++) begin
      case (kind)
        0: begin idx_vec[i*IW +: IW] = 32'(i * 2); off_vec[i*IW +: IW] = 32'($urandom % 64); end
        1: begin idx_vec[i*IW +: IW] = 32'($urandom % 64); off_vec[i*IW +: IW] = 32'(i); end
        default: begin
          idx_vec[i*IW +: IW] = (i[0]) ? $urandom : 32'($urandom % 300);
          off_vec[i*IW +: IW] = (i[1]) ? $urandom : 32'($urandom % 200);
        end
      endcase
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1 during reset
    check(busy === 1'b0 && lane_vld === 1'b0 && lane_oob === 1'b0 && done === 1'b0,
          "R1 reset outputs", 64'({busy, lane_vld, lane_oob, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mask_out === '0, "R1 reset mask", 64'(mask_out), 0);
    check(busy === 1'b0, "R1 idle after reset", 64'(busy), 0);

    // linear boundary: limit 1900, lane0 span 1892 in, lane1 span 1900 out (R7)
    d_base = 48'h1000; d_stride = 14'd16; d_fmt = 4'd3; d_nrec = 32'd2000;
    d_swz_en = 1'b0; d_tid_en = 1'b0; s_off = 32'd100; i_off = '0;
    exec_in = '1; set_vectors(0);
    idx_vec[0 +: IW] = 32'd118; off_vec[0 +: IW] = 32'd4;
    idx_vec[IW +: IW] = 32'd118; off_vec[IW +: IW] = 32'd12;
    run_wave(0);

    // scalar offset beyond record count: all active lanes out of bounds (R7)
    s_off = 32'd3000; exec_in = 64'hF0F0_1234_8000_0001;
    run_wave(0);

    // swizzled with thread-ID, stride 32, 40 records (R8, R9)
    d_swz_en = 1'b1; d_tid_en = 1'b1; d_fmt = 4'd0; d_stride = 14'd32; d_nrec = 32'd40;
    s_off = 32'd8; i_off = 12'd0; d_istr_sel = 2'd1; d_esz_sel = 2'd2; exec_in = '1;
    for (int i = 0; i < LANES; i++) begin
      idx_vec[i*IW +: IW] = '0;
      off_vec[i*IW +: IW] = 32'(i % 34);
    end
    run_wave(0);

    // swizzle enabled but effective stride zero: linear rules apply (R6)
    d_stride = 14'd0; d_tid_en = 1'b0; d_nrec = 32'd500; s_off = 32'd0; i_off = 12'd7;
    set_vectors(1);
    run_wave(0);

    // thread-ID stride with format field in linear mode (R4, R5)
    d_swz_en = 1'b0; d_tid_en = 1'b1; d_fmt = 4'd2; d_stride = 14'd100;
    d_nrec = 32'hFFFF_FFFF; s_off = 32'd5; i_off = 12'hFFF; exec_in = {$urandom, $urandom};
    set_vectors(1);
    run_wave(0);

    // random waves, one with a start raised mid-wave (R2)
    for (int w = 0; w < 16; w++) begin
      scramble();
      if (w % 3 == 0) d_nrec = $urandom % 400;
      if (w % 4 == 1) d_stride = 14'($urandom % 64);
      set_vectors(2);
      run_wave(w == 5);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule